// File: doc/BRIEF.md
# CORDIC Rectangular-to-Polar Converter

This block is a pipelined CORDIC engine in signed fixed point. Built in vectoring mode (the default), it takes a complex sample as a real part `in_x` and an imaginary part `in_y`. It returns the magnitude on `out_x` and the phase on `out_z`. The phase is scaled so that a code of +1.0 stands for +pi and -1.0 for -pi. Built in rotation mode, it turns the vector (`in_x`, `in_y`) by the angle `in_z`, also in units of pi, and returns the rotated vector on `out_x`/`out_y`.

A front stage sorts each sample into one of three pre-rotation classes:

- `QD_KEEP`: the vector is passed as is.
- `QD_TURN_POS`: the vector is negated and the angle register is preloaded with +1.0 (vectoring), or +1.0 is taken off the requested angle (rotation).
- `QD_TURN_NEG`: the mirror case, using -1.0.

The class is chosen from the sign of the real part (vectoring), or from whether the requested angle lies beyond ±0.5 (rotation). A chain of micro-rotation stages follows, one per iteration. A final stage multiplies by the inverse CORDIC gain (about 0.60725), rounds and saturates.

Samples may arrive on every clock. Each sample carries its own valid bit through the pipeline.

Top module: `cordic_polar_unit`

## Requirements
- R1: In vectoring mode, `out_x` equals sqrt(x²+y²) within 1e-4, for inputs with |x|,|y| ≤ 0.5. All data ports are two's complement with DW-1 fraction bits (17 by default).
- R2: In vectoring mode, `out_z` equals atan2(y, x)/pi within 1e-4. The code 2^(DW-1) stands for +1.0, which means +pi.
- R3: Every quadrant is covered. Inputs with a negative real part are pre-rotated by ±1.0. A sample with a positive real part and a negative imaginary part yields a negative phase.
- R4: On the negative real axis (y = 0, x < 0), the phase comes out near +1.0. It is saturated to the largest positive code and does not wrap to -1.0.
- R5: In vectoring mode, `in_z` has no effect on any output.
- R6: In rotation mode, (`out_x`, `out_y`) equals the input vector rotated by `in_z`·pi, within 1e-4, for any `in_z` in [-1, 1). `out_z` stays within 1e-4 of zero.
- R7: `out_valid` rises exactly ITERS+2 cycles (18 by default) after the cycle in which `in_valid` was sampled high.
- R8: One sample is accepted per cycle. Every accepted sample produces exactly one `out_valid` pulse, in order. Data presented while `in_valid` is low produces no output.
- R9: While `rst_n` is low, `out_valid` is low and the data outputs are zero.
- R10: In vectoring mode, the residual `out_y` of a valid result stays within 32 codes of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is present |
| in_x | input | DW | Real part / x coordinate |
| in_y | input | DW | Imaginary part / y coordinate |
| in_z | input | DW | Rotation angle in units of pi (rotation mode only) |
| out_valid | output | 1 | Result is present |
| out_x | output | DW | Magnitude (vectoring) or rotated x |
| out_y | output | DW | Residual (vectoring) or rotated y |
| out_z | output | DW | Phase in units of pi (vectoring) or residual angle |

## Verification
The hardest situations to reach from the ports are the seams of the pre-rotation:

- vectors lying exactly on the negative real axis, or one code below it, where the phase is at ±pi;
- requested angles at -1.0 and just under +1.0.

A near-exhaustive polar sweep of three radii and 64 angles reaches the general case in every quadrant. Hand-placed seam samples are added to that stream. Idle cycles carrying junk data are interleaved between samples, and stray angle values are fed to the vectoring build. Both builds receive the same stream side by side, and each result is compared against double-precision trigonometry.

// File: rtl/cordic_polar_pkg.sv
package cordic_polar_pkg;

    typedef enum logic [1:0] {
        QD_KEEP     = 2'd0,
        QD_TURN_POS = 2'd1,
        QD_TURN_NEG = 2'd2
    } quad_e;

    localparam real PI_R = 3.14159265358979323846;

    // atan(2^-idx)/pi scaled by 2^fb, rounded
    function automatic longint atan_pi_code(input int idx, input int fb);
        real a;
        a = $atan(1.0 / (2.0 ** idx)) / PI_R;
        return longint'($rtoi(a * (2.0 ** fb) + 0.5));
    endfunction

    // product of 1/sqrt(1+2^-2i) scaled by 2^fb, rounded
    function automatic longint inv_gain_code(input int iters, input int fb);
        real g;
        g = 1.0;
        for (int i = 0; i < iters; i++) begin
            g = g / $sqrt(1.0 + 2.0 ** (-2 * i));
        end
        return longint'($rtoi(g * (2.0 ** fb) + 0.5));
    endfunction

endpackage

// File: rtl/cordic_prerot.sv
module cordic_prerot
    import cordic_polar_pkg::*;
#(
    parameter int DW     = 18,
    parameter int GB     = 4,
    parameter int IW     = DW + 2 + GB,
    parameter bit ROTATE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    input  logic signed [DW-1:0] z_i,
    output logic                 v_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [IW-1:0] z_o
);
    localparam int IFB = DW - 1 + GB;
    localparam logic signed [IW-1:0] ONE  = {{(IW-IFB-1){1'b0}}, 1'b1, {IFB{1'b0}}};
    localparam logic signed [IW-1:0] HALF = {{(IW-IFB){1'b0}}, 1'b1, {(IFB-1){1'b0}}};

    logic signed [IW-1:0] xe, ye, ze, zb;
    logic signed [IW-1:0] x_n, y_n, z_n;
    quad_e                q;

    always_comb begin
        xe = {{(IW-DW-GB){x_i[DW-1]}}, x_i, {GB{1'b0}}};
        ye = {{(IW-DW-GB){y_i[DW-1]}}, y_i, {GB{1'b0}}};
        ze = {{(IW-DW-GB){z_i[DW-1]}}, z_i, {GB{1'b0}}};
    end

    generate
        if (ROTATE) begin : g_rot_class
            always_comb begin
                zb = ze;
                if (ze > HALF)       q = QD_TURN_POS;
                else if (ze < -HALF) q = QD_TURN_NEG;
                else                 q = QD_KEEP;
            end
        end else begin : g_vec_class
            logic unused_z;
            assign unused_z = ^ze;
            always_comb begin
                zb = '0;
                if (!x_i[DW-1])      q = QD_KEEP;
                else if (!y_i[DW-1]) q = QD_TURN_POS;
                else                 q = QD_TURN_NEG;
            end
        end
    endgenerate

    always_comb begin
        unique case (q)
            QD_KEEP: begin
                x_n = xe;
                y_n = ye;
                z_n = zb;
            end
            QD_TURN_POS: begin
                x_n = -xe;
                y_n = -ye;
                z_n = ROTATE ? (zb - ONE) : (zb + ONE);
            end
            QD_TURN_NEG: begin
                x_n = -xe;
                y_n = -ye;
                z_n = ROTATE ? (zb + ONE) : (zb - ONE);
            end
            default: begin
                x_n = xe;
                y_n = ye;
                z_n = zb;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else begin
            v_o <= v_i;
            x_o <= x_n;
            y_o <= y_n;
            z_o <= z_n;
        end
    end

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
    import cordic_polar_pkg::*;
#(
    parameter int IW     = 24,
    parameter int IFB    = 21,
    parameter int IDX    = 0,
    parameter bit ROTATE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [IW-1:0] z_i,
    output logic                 v_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [IW-1:0] z_o
);
    localparam longint               ANG_L = atan_pi_code(IDX, IFB);
    localparam logic signed [IW-1:0] ANG   = ANG_L[IW-1:0];

    logic signed [IW-1:0] xs, ys, x_n, y_n, z_n;
    logic                 cw;

    always_comb begin
        xs = x_i >>> IDX;
        ys = y_i >>> IDX;
        // clockwise step: angle accumulator goes up
        cw = ROTATE ? z_i[IW-1] : ~y_i[IW-1];
        if (cw) begin
            x_n = x_i + ys;
            y_n = y_i - xs;
            z_n = z_i + ANG;
        end else begin
            x_n = x_i - ys;
            y_n = y_i + xs;
            z_n = z_i - ANG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else begin
            v_o <= v_i;
            x_o <= x_n;
            y_o <= y_n;
            z_o <= z_n;
        end
    end

endmodule

// File: rtl/cordic_post.sv
module cordic_post
    import cordic_polar_pkg::*;
#(
    parameter int DW    = 18,
    parameter int GB    = 4,
    parameter int IW    = DW + 2 + GB,
    parameter int ITERS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [IW-1:0] z_i,
    output logic                 v_o,
    output logic signed [DW-1:0] x_o,
    output logic signed [DW-1:0] y_o,
    output logic signed [DW-1:0] z_o
);
    localparam int                   IFB  = DW - 1 + GB;
    localparam longint               KL   = inv_gain_code(ITERS, IFB);
    localparam logic signed [IW-1:0] KS   = KL[IW-1:0];
    localparam logic signed [IW-1:0] RND  = {{(IW-GB){1'b0}}, 1'b1, {(GB-1){1'b0}}};
    localparam logic signed [IW-1:0] MAXW = {{(IW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [IW-1:0] MINW = {{(IW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    function automatic logic signed [DW-1:0] rnd_sat(input logic signed [IW-1:0] v);
        logic signed [IW-1:0] r;
        r = (v + RND) >>> GB;
        if (r > MAXW)      return MAXW[DW-1:0];
        else if (r < MINW) return MINW[DW-1:0];
        else               return r[DW-1:0];
    endfunction

    logic signed [2*IW-1:0] px, py;
    logic signed [IW-1:0]   xk, yk;

    always_comb begin
        px = (2*IW)'(x_i) * (2*IW)'(KS);
        py = (2*IW)'(y_i) * (2*IW)'(KS);
        xk = IW'(px >>> IFB);
        yk = IW'(py >>> IFB);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else begin
            v_o <= v_i;
            x_o <= rnd_sat(xk);
            y_o <= rnd_sat(yk);
            z_o <= rnd_sat(z_i);
        end
    end

endmodule

// File: rtl/cordic_polar_unit.sv
module cordic_polar_unit
    import cordic_polar_pkg::*;
#(
    parameter int DW     = 18,
    parameter int ITERS  = 16,
    parameter int GB     = 4,
    parameter bit ROTATE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_x,
    input  logic signed [DW-1:0] in_y,
    input  logic signed [DW-1:0] in_z,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_x,
    output logic signed [DW-1:0] out_y,
    output logic signed [DW-1:0] out_z
);
    localparam int IW  = DW + 2 + GB;
    localparam int IFB = DW - 1 + GB;

    logic                 stage_vld [0:ITERS];
    logic signed [IW-1:0] sx [0:ITERS];
    logic signed [IW-1:0] sy [0:ITERS];
    logic signed [IW-1:0] sz [0:ITERS];
    logic [ITERS:0]       stage_vld_vec;

    cordic_prerot #(.DW(DW), .GB(GB), .IW(IW), .ROTATE(ROTATE)) u_prerot (
        .clk(clk), .rst_n(rst_n),
        .v_i(in_valid), .x_i(in_x), .y_i(in_y), .z_i(in_z),
        .v_o(stage_vld[0]), .x_o(sx[0]), .y_o(sy[0]), .z_o(sz[0])
    );

    generate
        for (genvar k = 0; k < ITERS; k++) begin : g_stage
            cordic_stage #(.IW(IW), .IFB(IFB), .IDX(k), .ROTATE(ROTATE)) u_stage (
                .clk(clk), .rst_n(rst_n),
                .v_i(stage_vld[k]), .x_i(sx[k]), .y_i(sy[k]), .z_i(sz[k]),
                .v_o(stage_vld[k+1]), .x_o(sx[k+1]), .y_o(sy[k+1]), .z_o(sz[k+1])
            );
        end
        for (genvar j = 0; j <= ITERS; j++) begin : g_vec
            assign stage_vld_vec[j] = stage_vld[j];
        end
    endgenerate

    cordic_post #(.DW(DW), .GB(GB), .IW(IW), .ITERS(ITERS)) u_post (
        .clk(clk), .rst_n(rst_n),
        .v_i(stage_vld[ITERS]), .x_i(sx[ITERS]), .y_i(sy[ITERS]), .z_i(sz[ITERS]),
        .v_o(out_valid), .x_o(out_x), .y_o(out_y), .z_o(out_z)
    );

endmodule

// File: rtl/cordic_polar_chk.sv
module cordic_polar_chk #(
    parameter int DW     = 18,
    parameter int ITERS  = 16,
    parameter bit ROTATE = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic [ITERS:0]       stage_vld,
    input logic signed [DW-1:0] out_y,
    input logic signed [DW-1:0] out_z
);
    AST_ENTRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> stage_vld[0]); // R7
    AST_ENTRY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !stage_vld[0]); // R8

    generate
        for (genvar k = 0; k < ITERS; k++) begin : g_chain
            AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                stage_vld[k] |=> stage_vld[k+1]); // R7
            AST_CHAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                !stage_vld[k] |=> !stage_vld[k+1]); // R8
        end
    endgenerate

    AST_DRAIN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        stage_vld[ITERS] |=> out_valid); // R7
    AST_DRAIN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_vld[ITERS] |=> !out_valid); // R8

    generate
        if (ROTATE) begin : g_rot_chk
            logic unused_y;
            assign unused_y = ^out_y;
            AST_ANGLE_RESIDUAL: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_z <= 16 && out_z >= -16)); // R6
        end else begin : g_vec_chk
            logic unused_zr;
            assign unused_zr = ^out_z;
            AST_Y_RESIDUAL: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_y <= 32 && out_y >= -32)); // R10
        end
    endgenerate

endmodule

bind cordic_polar_unit cordic_polar_chk #(.DW(DW), .ITERS(ITERS), .ROTATE(ROTATE)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .stage_vld(stage_vld_vec), .out_y(out_y), .out_z(out_z)
);

// File: tb/cordic_polar_unit_bench.sv
module cordic_polar_unit_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  DW    = 18;
    localparam int  ITERS = 16;
    localparam int  LAT   = ITERS + 2;
    localparam int  NMAX  = 512;
    localparam real FS    = 131072.0;
    localparam real TOL   = 1.0e-4;
    localparam real PI_R  = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic signed [DW-1:0] in_x, in_y, in_z;
    logic vo_valid, ro_valid;
    logic signed [DW-1:0] vo_x, vo_y, vo_z, ro_x, ro_y, ro_z;

    always #(CLK_PERIOD/2) clk = ~clk;

    cordic_polar_unit #(.DW(DW), .ITERS(ITERS), .ROTATE(1'b0)) u_cordic_polar_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .out_valid(vo_valid), .out_x(vo_x), .out_y(vo_y), .out_z(vo_z));

    cordic_polar_unit #(.DW(DW), .ITERS(ITERS), .ROTATE(1'b1)) u_rot (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .out_valid(ro_valid), .out_x(ro_x), .out_y(ro_y), .out_z(ro_z));

    int cx [NMAX];
    int cy [NMAX];
    int cz [NMAX];
    int tg [NMAX];
    int n_in = 0;
    int vi = 0;
    int ri = 0;
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int t0 = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic add(input real x, input real y, input real z, input int t);
        cx[n_in] = $rtoi(x * FS);
        cy[n_in] = $rtoi(y * FS);
        cz[n_in] = $rtoi(z * FS);
        tg[n_in] = t;
        n_in++;
    endtask

    task automatic chk(input real act, input real exp, input string rq, input string what);
        checks++;
        if (act - exp > TOL || exp - act > TOL) begin
            fails++;
            $display("FAIL %s %s actual=%f expected=%f", rq, what, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string rq, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // vectoring results
    always @(negedge clk) begin
        if (rst_n && vo_valid && !done) begin
            if (vi == 0) chk_int(cyc - t0, LAT, "R7", "vectoring latency");
            if (vi < n_in) begin
                real x, y, em, ep;
                string rm, rp;
                x  = $itor(cx[vi]) / FS;
                y  = $itor(cy[vi]) / FS;
                em = $sqrt(x * x + y * y);
                ep = $atan2(y, x) / PI_R;
                rm = (tg[vi] == 5) ? "R5" : "R1";
                rp = (tg[vi] == 3) ? "R3" : (tg[vi] == 4) ? "R4" : (tg[vi] == 5) ? "R5" : "R2";
                chk($itor(vo_x) / FS, em, rm, $sformatf("magnitude #%0d", vi));
                chk($itor(vo_z) / FS, ep, rp, $sformatf("phase #%0d", vi));
            end
            vi++;
        end
    end

    // rotation results
    always @(negedge clk) begin
        if (rst_n && ro_valid && !done) begin
            if (ri == 0) chk_int(cyc - t0, LAT, "R7", "rotation latency");
            if (ri < n_in) begin
                real x, y, a;
                x = $itor(cx[ri]) / FS;
                y = $itor(cy[ri]) / FS;
                a = ($itor(cz[ri]) / FS) * PI_R;
                chk($itor(ro_x) / FS, x * $cos(a) - y * $sin(a), "R6", $sformatf("rot x #%0d", ri));
                chk($itor(ro_y) / FS, x * $sin(a) + y * $cos(a), "R6", $sformatf("rot y #%0d", ri));
                chk($itor(ro_z) / FS, 0.0, "R6", $sformatf("rot residual #%0d", ri));
            end
            ri++;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL R8 watchdog expired actual=hang expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_x = '0; in_y = '0; in_z = '0;
        // polar sweep, stray angles for both builds
        for (int r = 0; r < 3; r++) begin
            real rad;
            rad = (r == 0) ? 0.05 : (r == 1) ? 0.25 : 0.49;
            for (int k = 0; k < 64; k++) begin
                real th;
                th = 2.0 * PI_R * $itor(k) / 64.0 + 0.013;
                add(rad * $cos(th), rad * $sin(th), 0.95 * $sin(0.37 * $itor(k + 64 * r)), 1);
            end
        end
        // quadrant seams
        add(0.117, -0.46, 0.1, 3);
        add(0.0, 0.3, 0.2, 3);
        add(0.0, -0.3, -0.2, 3);
        add(0.3, 0.0, 0.3, 3);
        add(-0.3, 0.3, -0.3, 3);
        add(-0.3, -0.3, 0.45, 3);
        // negative real axis
        add(-0.4, 0.0, 0.0, 4);
        add(-0.4, -1.0 / FS, 0.0, 4);
        add(-0.49, 0.0, 0.6, 4);
        // angle input must not matter in vectoring build
        add(0.2, 0.1, 0.9, 5);
        add(0.2, 0.1, -0.9, 5);
        add(0.2, 0.1, -1.0, 5);
        // rotation angle limits
        add(0.3, 0.1, -1.0, 6);
        add(0.3, 0.1, -0.5, 6);
        add(0.3, 0.1, 0.5, 6);
        add(0.3, 0.1, 0.99, 6);
        add(-0.45, 0.2, 0.51, 6);

        repeat (4) @(negedge clk);
        chk_int(int'(vo_valid), 0, "R9", "valid in reset");
        chk_int(int'(ro_valid), 0, "R9", "rotation valid in reset");
        chk_int(int'(vo_x), 0, "R9", "magnitude in reset");
        chk_int(int'(vo_z), 0, "R9", "phase in reset");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < n_in; i++) begin
            if (i % 7 == 3) begin
                in_valid = 1'b0;
                in_x = 18'sd50000; in_y = -18'sd40000; in_z = 18'sd1000;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_x = DW'(cx[i]); in_y = DW'(cy[i]); in_z = DW'(cz[i]);
            if (i == 0) t0 = cyc;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_x = 18'sd60000; in_y = 18'sd60000; in_z = 18'sd60000;
        repeat (LAT + 6) @(negedge clk);
        done = 1'b1;
        chk_int(vi, n_in, "R8", "vectoring result count");
        chk_int(ri, n_in, "R8", "rotation result count");
        chk_int(int'(vo_valid), 0, "R8", "vectoring idle valid");
        chk_int(int'(ro_valid), 0, "R8", "rotation idle valid");
        finish_run();
    end

endmodule